// File: doc/BRIEF.md
# Power-Up Sequencer and Reset Generator

This block starts two switching converters in a fixed order and drives three active-low reset outputs. The first converter feeds the second, so the second may start only once the first has finished its soft-start and sits inside its voltage window. Before any switching there is a fixed enable delay, and an output discharge pull-down is active during that delay. Converter 1 then soft-starts, and converter 2 soft-starts after it. Input under-voltage, input over-voltage, thermal shutdown and driver-supply power-on reset stop both converters. A short on either converter starts a timed off period, after which the converter chain powers up again.

The enable pin is filtered. A low pulse shorter than the disable response time has no effect. A longer low pulse shuts everything down, and the next high level restarts from the enable delay. The comparator flags for each monitored voltage are synchronized through two flops and filtered against glitches. Each reset output has its own fault routing and its own release delay. A release delay of zero makes that output a plain power-good signal. All times are parameters counted in pulses of a slow `tick` input.

The sequencer has six one-hot states. OFF goes to EN_DELAY when enable is high. EN_DELAY goes to SS1 when the delay timer expires. SS1 goes to SS2 when the timer expires and rail 1 is inside its window. SS2 goes to RUN when the timer expires. SS1, SS2 and RUN go to HICCUP on a short. HICCUP goes back to SS1 when its timer expires. Any global fault forces EN_DELAY from every state except OFF, and holds it there. A filtered enable-low forces OFF from every state.

Top module: `pwr_seq_top`

## Requirements
- R1: After `en_in` is sampled high in OFF, both converter enables stay low for EN_DLY_TICKS ticks. `out_pd` is high only during this delay. Converter 1 is enabled on the cycle after the delay timer expires.
- R2: Converter 1 soft-starts (`conv1_en`=1, `conv1_ss`=1) for SS1_TICKS ticks. Converter 2 is enabled only after that timer has expired and rail 1 is in its window. It then soft-starts (`conv2_ss`=1) for SS2_TICKS ticks, and the block enters RUN with both soft-start flags low.
- R3: `en_in` must stay low for DIS_TICKS ticks before the sequencer turns off. A shorter low pulse changes nothing. After a full turn-off, the next high level restarts at the enable delay.
- R4: Any of `vin_uv`, `vin_ov`, `therm_sd` or `drv_por` turns both converters off on the next cycle and sends the sequencer to EN_DELAY. The delay timer is held at zero while the fault lasts, and the full delay runs after the fault clears.
- R5: `rst_out_n[0]` (rail 1) is held low while rail 1 is out of its window. While `v1_above_2v`=1, it is also held low by `therm_sd`, `vin_uv`, `vin_ov`, `wd_fault`, or a filtered enable-low. `drv_por` does not affect it.
- R6: `rst_out_n[1]` (rail 2) is held low by its own window excursion and by `vin_uv`, `vin_ov` or `therm_sd`. `rst_out_n[2]` (external rail) is held low only by its own window excursion.
- R7: When its hold condition clears, each reset output goes high after its own delay in ticks. Bit 0 uses RST1_DLY, bit 1 uses RST2_DLY and bit 2 uses RSTX_DLY. With a delay of zero, the output goes high on the next clock.
- R8: For rail i, `win_above[i]`=1 means the voltage is above the window and `win_below[i]`=1 means it is below. Both flags pass two synchronizer flops. A change is accepted only after it has persisted for FILT_TICKS ticks, so shorter glitches are ignored.
- R9: A short (`short1` in SS1, SS2 or RUN, or `short2` in SS2 or RUN) turns both converters off for HIC_TICKS ticks. Converter 1 soft-start then begins again.
- R10: During and just after reset, all converter controls and `out_pd` are low and all three reset outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base pulse, one clock wide |
| en_in | input | 1 | Master enable |
| vin_uv | input | 1 | Input under-voltage flag |
| vin_ov | input | 1 | Input over-voltage flag |
| therm_sd | input | 1 | Thermal shutdown flag |
| drv_por | input | 1 | Driver-supply power-on reset flag |
| v1_above_2v | input | 1 | Rail 1 is above about 2 V |
| win_above | input | 3 | Above-window comparator flags (0 rail 1, 1 rail 2, 2 external) |
| win_below | input | 3 | Below-window comparator flags (same order) |
| wd_fault | input | 1 | Watchdog fault flag |
| short1 | input | 1 | Short-circuit detect, converter 1 |
| short2 | input | 1 | Short-circuit detect, converter 2 |
| conv1_en | output | 1 | Converter 1 enable |
| conv1_ss | output | 1 | Converter 1 soft-start active |
| conv2_en | output | 1 | Converter 2 enable |
| conv2_ss | output | 1 | Converter 2 soft-start active |
| out_pd | output | 1 | Output discharge pull-down enable |
| rst_out_n | output | 3 | Active-low reset outputs (0 rail 1, 1 rail 2, 2 external) |

## Verification
Converter controls and `out_pd` are decoded from the state register. They change one clock after a fault, a short, or an accepted enable edge. After a timer expires they change on the clock that follows the last counted tick. A reset output falls one clock after its hold condition rises. A window excursion takes two synchronizer clocks plus FILT_TICKS ticks before it reaches the reset output. A release takes one more tick per programmed delay tick. The bench counts ticks at the clock edges that consume them and samples on the falling edge. Where the synchronizer's unseen tick could shift the count, it checks an earliest bound and a latest bound instead of an exact cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int NUM_RAILS = 3;
    localparam int RAIL_V1   = 0;
    localparam int RAIL_V2   = 1;
    localparam int RAIL_EXT  = 2;

    typedef enum logic [5:0] {
        ST_OFF    = 6'b000001,
        ST_DELAY  = 6'b000010,
        ST_SS1    = 6'b000100,
        ST_SS2    = 6'b001000,
        ST_RUN    = 6'b010000,
        ST_HICCUP = 6'b100000
    } seq_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pwr_win_filter.sv
module pwr_win_filter #(
    parameter int FILT_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic above_i,
    input  logic below_i,
    output logic in_win_o
);
    localparam int CW = $clog2(FILT_TICKS + 1);

    logic [1:0]    meta_q;
    logic [1:0]    sync_q;
    logic          raw_out;
    logic          excur_q;
    logic [CW-1:0] cnt_q;

    assign raw_out = |sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            sync_q  <= '0;
            excur_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            meta_q <= {above_i, below_i};
            sync_q <= meta_q;
            if (raw_out == excur_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == CW'(FILT_TICKS - 1)) begin
                    excur_q <= raw_out;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign in_win_o = !excur_q;

    AST_FILT_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(excur_q)); // R8

endmodule

// File: rtl/pwr_rst_delay.sv
module pwr_rst_delay #(
    parameter int DLY_TICKS = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_i,
    output logic rst_n_o
);
    logic rel_q;

    generate
        if (DLY_TICKS == 0) begin : g_pgood
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rel_q <= 1'b0;
                else        rel_q <= !hold_i;
            end
        end else begin : g_delay
            localparam int CW = $clog2(DLY_TICKS + 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rel_q <= 1'b0;
                    cnt_q <= '0;
                end else if (hold_i) begin
                    rel_q <= 1'b0;
                    cnt_q <= '0;
                end else if (!rel_q && tick) begin
                    if (cnt_q == CW'(DLY_TICKS - 1)) rel_q <= 1'b1;
                    else                             cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    assign rst_n_o = rel_q;

    AST_HOLD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !rst_n_o); // R7

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int EN_DLY_TICKS = 16000,
    parameter int SS1_TICKS    = 1400,
    parameter int SS2_TICKS    = 1400,
    parameter int HIC_TICKS    = 31,
    parameter int DIS_TICKS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en_i,
    input  logic gfault_i,
    input  logic v1_ok_i,
    input  logic short1_i,
    input  logic short2_i,
    output logic conv1_en_o,
    output logic conv1_ss_o,
    output logic conv2_en_o,
    output logic conv2_ss_o,
    output logic pull_dn_o,
    output logic en_off_o
);
    localparam int MAXT = max_of4(EN_DLY_TICKS, SS1_TICKS, SS2_TICKS, HIC_TICKS);
    localparam int CW   = $clog2(MAXT + 1);
    localparam int DW   = $clog2(DIS_TICKS + 1);

    seq_state_e    state_q, state_nxt;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          done;
    logic          clear_cnt;
    logic [DW-1:0] dis_q;

    // enable-low qualification
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              dis_q <= DW'(DIS_TICKS);
        else if (en_i)                           dis_q <= '0;
        else if (tick && dis_q != DW'(DIS_TICKS)) dis_q <= dis_q + 1'b1;
    end
    assign en_off_o = (dis_q == DW'(DIS_TICKS));

    always_comb begin
        limit = '0;
        unique case (state_q)
            ST_DELAY:  limit = CW'(EN_DLY_TICKS);
            ST_SS1:    limit = CW'(SS1_TICKS);
            ST_SS2:    limit = CW'(SS2_TICKS);
            ST_HICCUP: limit = CW'(HIC_TICKS);
            default:   limit = '0;
        endcase
    end
    assign done = (cnt_q == limit);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_nxt = ST_DELAY;
            end
            ST_DELAY: begin
                if (en_off_o)      state_nxt = ST_OFF;
                else if (!gfault_i && done) state_nxt = ST_SS1;
            end
            ST_SS1: begin
                if (en_off_o)              state_nxt = ST_OFF;
                else if (gfault_i)         state_nxt = ST_DELAY;
                else if (short1_i)         state_nxt = ST_HICCUP;
                else if (done && v1_ok_i)  state_nxt = ST_SS2;
            end
            ST_SS2: begin
                if (en_off_o)                   state_nxt = ST_OFF;
                else if (gfault_i)              state_nxt = ST_DELAY;
                else if (short1_i || short2_i)  state_nxt = ST_HICCUP;
                else if (done)                  state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (en_off_o)                   state_nxt = ST_OFF;
                else if (gfault_i)              state_nxt = ST_DELAY;
                else if (short1_i || short2_i)  state_nxt = ST_HICCUP;
            end
            ST_HICCUP: begin
                if (en_off_o)      state_nxt = ST_OFF;
                else if (gfault_i) state_nxt = ST_DELAY;
                else if (done)     state_nxt = ST_SS1;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    assign clear_cnt = (state_nxt != state_q) || gfault_i;

    // state register and phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (clear_cnt)          cnt_q <= '0;
            else if (tick && !done) cnt_q <= cnt_q + 1'b1;
        end
    end

    // output decode
    always_comb begin
        conv1_en_o = 1'b0;
        conv1_ss_o = 1'b0;
        conv2_en_o = 1'b0;
        conv2_ss_o = 1'b0;
        pull_dn_o  = 1'b0;
        unique case (state_q)
            ST_DELAY: pull_dn_o = 1'b1;
            ST_SS1: begin
                conv1_en_o = 1'b1;
                conv1_ss_o = 1'b1;
            end
            ST_SS2: begin
                conv1_en_o = 1'b1;
                conv2_en_o = 1'b1;
                conv2_ss_o = 1'b1;
            end
            ST_RUN: begin
                conv1_en_o = 1'b1;
                conv2_en_o = 1'b1;
            end
            default: ;
        endcase
    end

    AST_FAULT_STOPS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        gfault_i |=> (!conv1_en_o && !conv2_en_o)); // R4

    AST_CONV2_NEEDS_RAIL1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv2_en_o) |-> $past(v1_ok_i)); // R2

    AST_CONV2_UNDER_CONV1: assert property (@(posedge clk) disable iff (!rst_n)
        conv2_en_o |-> conv1_en_o); // R2

    AST_SHORT_STOPS_CONV2: assert property (@(posedge clk) disable iff (!rst_n)
        ((short1_i || short2_i) && conv2_en_o) |=> !conv2_en_o); // R9

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int EN_DLY_TICKS = 16000,
    parameter int SS1_TICKS    = 1400,
    parameter int SS2_TICKS    = 1400,
    parameter int HIC_TICKS    = 31,
    parameter int DIS_TICKS    = 10,
    parameter int FILT_TICKS   = 25,
    parameter int RST1_DLY     = 5000,
    parameter int RST2_DLY     = 5000,
    parameter int RSTX_DLY     = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en_in,
    input  logic       vin_uv,
    input  logic       vin_ov,
    input  logic       therm_sd,
    input  logic       drv_por,
    input  logic       v1_above_2v,
    input  logic [2:0] win_above,
    input  logic [2:0] win_below,
    input  logic       wd_fault,
    input  logic       short1,
    input  logic       short2,
    output logic       conv1_en,
    output logic       conv1_ss,
    output logic       conv2_en,
    output logic       conv2_ss,
    output logic       out_pd,
    output logic [2:0] rst_out_n
);
    logic [NUM_RAILS-1:0] in_win;
    logic [NUM_RAILS-1:0] hold;
    logic                 en_off;
    logic                 gfault;
    logic                 supply_fault;

    assign supply_fault = vin_uv | vin_ov | therm_sd;
    assign gfault       = supply_fault | drv_por;

    generate
        for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
            localparam int DLY = (i == RAIL_V1) ? RST1_DLY :
                                 (i == RAIL_V2) ? RST2_DLY : RSTX_DLY;
            pwr_win_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .above_i  (win_above[i]),
                .below_i  (win_below[i]),
                .in_win_o (in_win[i])
            );
            pwr_rst_delay #(.DLY_TICKS(DLY)) u_dly (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .hold_i  (hold[i]),
                .rst_n_o (rst_out_n[i])
            );
        end
    endgenerate

    always_comb begin
        hold[RAIL_V1]  = !in_win[RAIL_V1] |
                         (v1_above_2v & (supply_fault | wd_fault | en_off));
        hold[RAIL_V2]  = !in_win[RAIL_V2] | supply_fault;
        hold[RAIL_EXT] = !in_win[RAIL_EXT];
    end

    pwr_seq_fsm #(
        .EN_DLY_TICKS (EN_DLY_TICKS),
        .SS1_TICKS    (SS1_TICKS),
        .SS2_TICKS    (SS2_TICKS),
        .HIC_TICKS    (HIC_TICKS),
        .DIS_TICKS    (DIS_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .en_i       (en_in),
        .gfault_i   (gfault),
        .v1_ok_i    (in_win[RAIL_V1]),
        .short1_i   (short1),
        .short2_i   (short2),
        .conv1_en_o (conv1_en),
        .conv1_ss_o (conv1_ss),
        .conv2_en_o (conv2_en),
        .conv2_ss_o (conv2_ss),
        .pull_dn_o  (out_pd),
        .en_off_o   (en_off)
    );

    AST_PD_NO_SWITCHING: assert property (@(posedge clk) disable iff (!rst_n)
        out_pd |-> (!conv1_en && !conv2_en)); // R1

    AST_EXT_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win[RAIL_EXT] && $past(in_win[RAIL_EXT]) && $past(rst_out_n[RAIL_EXT]))
        |-> rst_out_n[RAIL_EXT]); // R6

endmodule

// File: tb/pwr_seq_top_test.sv
module pwr_seq_top_test;

    localparam int EN_DLY = 8;
    localparam int SS1    = 4;
    localparam int SS2    = 3;
    localparam int HIC    = 6;
    localparam int DIS    = 3;
    localparam int FILT   = 2;
    localparam int D1     = 5;
    localparam int D2     = 0;
    localparam int DX     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en_in = 1'b0;
    logic       vin_uv = 1'b0;
    logic       vin_ov = 1'b0;
    logic       therm_sd = 1'b0;
    logic       drv_por = 1'b0;
    logic       v1_above_2v = 1'b0;
    logic [2:0] win_above = '0;
    logic [2:0] win_below = '0;
    logic       wd_fault = 1'b0;
    logic       short1 = 1'b0;
    logic       short2 = 1'b0;
    logic       conv1_en, conv1_ss, conv2_en, conv2_ss, out_pd;
    logic [2:0] rst_out_n;

    int n_checks = 0;
    int n_bad = 0;

    pwr_seq_top #(
        .EN_DLY_TICKS(EN_DLY), .SS1_TICKS(SS1), .SS2_TICKS(SS2),
        .HIC_TICKS(HIC), .DIS_TICKS(DIS), .FILT_TICKS(FILT),
        .RST1_DLY(D1), .RST2_DLY(D2), .RSTX_DLY(DX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en_in(en_in),
        .vin_uv(vin_uv), .vin_ov(vin_ov), .therm_sd(therm_sd),
        .drv_por(drv_por), .v1_above_2v(v1_above_2v),
        .win_above(win_above), .win_below(win_below),
        .wd_fault(wd_fault), .short1(short1), .short2(short2),
        .conv1_en(conv1_en), .conv1_ss(conv1_ss), .conv2_en(conv2_en),
        .conv2_ss(conv2_ss), .out_pd(out_pd), .rst_out_n(rst_out_n)
    );

    initial forever #4 clk = ~clk;

    initial begin : tick_gen
        int div;
        div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait for n clock edges that consume a tick, then sample at the falling edge
    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    function automatic int ctl();
        return {conv1_en, conv1_ss, conv2_en, conv2_ss, out_pd};
    endfunction

    // from EN_DELAY entry (counter already cleared) to RUN
    task automatic settle_run(input string req);
        wait_ticks(EN_DLY + SS1 + SS2 + 4);
        negs(2);
        chk_eq({req, " back in run"}, ctl(), 5'b10100);
    endtask

    task automatic t_reset();
        negs(3);
        chk_eq("R10 controls in reset", ctl(), 0);
        chk_eq("R10 resets in reset", rst_out_n, 0);
        rst_n = 1'b1;
        negs(1);
        chk_eq("R10 resets after release", rst_out_n, 0);
        chk_eq("R10 controls after release", ctl(), 0);
        wait_ticks(FILT + D1 + 3);
        chk_eq("R7 all rails released", rst_out_n, 3'b111);
    endtask

    task automatic t_power_up();
        en_in = 1'b1;
        negs(1);
        chk_eq("R1 delay entered", ctl(), 5'b00001);
        wait_ticks(EN_DLY);
        chk_eq("R1 still delaying at limit", ctl(), 5'b00001);
        negs(1);
        chk_eq("R1 R2 conv1 soft start", ctl(), 5'b11000);
        wait_ticks(SS1);
        chk_eq("R2 conv2 waits for ss1", ctl(), 5'b11000);
        negs(1);
        chk_eq("R2 conv2 soft start", ctl(), 5'b10110);
        wait_ticks(SS2);
        chk_eq("R2 ss2 holds", conv2_ss, 1);
        negs(1);
        chk_eq("R2 run", ctl(), 5'b10100);
        v1_above_2v = 1'b1;
    endtask

    task automatic t_routing();
        wd_fault = 1'b1;
        negs(2);
        chk_eq("R5 watchdog pulls rail1", rst_out_n, 3'b110);
        chk_eq("R5 watchdog keeps converters", ctl(), 5'b10100);
        wd_fault = 1'b0;
        wait_ticks(D1 - 1);
        chk_eq("R7 rail1 still held in delay", rst_out_n[0], 0);
        wait_ticks(1);
        chk_eq("R7 rail1 released after delay", rst_out_n[0], 1);
        v1_above_2v = 1'b0;
        wd_fault = 1'b1;
        negs(3);
        chk_eq("R5 watchdog gated below 2V", rst_out_n, 3'b111);
        wd_fault = 1'b0;
        therm_sd = 1'b1;
        negs(1);
        chk_eq("R4 thermal stops converters", ctl(), 5'b00001);
        negs(1);
        chk_eq("R5 R6 thermal routing below 2V", rst_out_n, 3'b101);
        therm_sd = 1'b0;
        negs(2);
        chk_eq("R7 zero delay power good", rst_out_n[1], 1);
        v1_above_2v = 1'b1;
        settle_run("R4");
    endtask

    task automatic t_fault();
        vin_uv = 1'b1;
        negs(1);
        chk_eq("R4 undervoltage stops converters", ctl(), 5'b00001);
        negs(1);
        chk_eq("R5 R6 undervoltage routing", rst_out_n, 3'b100);
        wait_ticks(EN_DLY + 2);
        chk_eq("R4 delay held during fault", ctl(), 5'b00001);
        vin_uv = 1'b0;
        wait_ticks(EN_DLY);
        chk_eq("R4 full delay after fault", ctl(), 5'b00001);
        negs(1);
        chk_eq("R4 resumes soft start", ctl(), 5'b11000);
        wait_ticks(SS1 + SS2 + 2);
        negs(1);
        chk_eq("R4 run after resume", ctl(), 5'b10100);
        drv_por = 1'b1;
        negs(1);
        chk_eq("R4 driver por stops converters", ctl(), 5'b00001);
        negs(1);
        chk_eq("R5 R6 driver por not routed", rst_out_n, 3'b111);
        drv_por = 1'b0;
        settle_run("R4");
    endtask

    task automatic t_short();
        short2 = 1'b1;
        negs(1);
        short2 = 1'b0;
        chk_eq("R9 short stops converters", ctl(), 0);
        wait_ticks(HIC);
        chk_eq("R9 off for hiccup time", ctl(), 0);
        negs(1);
        chk_eq("R9 restarts soft start", ctl(), 5'b11000);
        wait_ticks(SS1 + SS2 + 2);
        negs(1);
        chk_eq("R9 run after hiccup", ctl(), 5'b10100);
    endtask

    task automatic t_enable();
        en_in = 1'b0;
        negs(6);
        en_in = 1'b1;
        negs(2);
        chk_eq("R3 short enable low ignored", ctl(), 5'b10100);
        chk_eq("R3 short enable low no reset", rst_out_n[0], 1);
        wait_ticks(DIS + 1);
        en_in = 1'b0;
        wait_ticks(DIS);
        negs(1);
        chk_eq("R3 long enable low turns off", ctl(), 0);
        chk_eq("R5 enable low pulls rail1", rst_out_n[0], 0);
        // rail 1 out of window while restarting
        win_below[0] = 1'b1;
        negs(3);
        wait_ticks(FILT + 1);
        en_in = 1'b1;
        negs(1);
        chk_eq("R3 restart enters delay", ctl(), 5'b00001);
        wait_ticks(EN_DLY);
        negs(1);
        wait_ticks(SS1 + 3);
        chk_eq("R2 conv2 held while rail1 out", ctl(), 5'b11000);
        chk_eq("R5 rail1 window hold", rst_out_n[0], 0);
        win_below[0] = 1'b0;
        negs(3);
        wait_ticks(FILT);
        negs(2);
        chk_eq("R2 conv2 starts when rail1 in", conv2_en, 1);
        wait_ticks(SS2 + 1);
        negs(1);
        chk_eq("R2 run after late rail1", ctl(), 5'b10100);
        wait_ticks(D1 + 1);
        chk_eq("R7 rail1 released", rst_out_n[0], 1);
    endtask

    task automatic t_window();
        win_above[2] = 1'b1;
        negs(3);
        win_above[2] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wait_ticks(1);
            chk_eq("R8 glitch ignored", rst_out_n[2], 1);
        end
        win_above[1] = 1'b1;
        negs(3);
        wait_ticks(FILT);
        negs(2);
        chk_eq("R6 rail2 excursion", rst_out_n, 3'b101);
        chk_eq("R6 excursion keeps converters", ctl(), 5'b10100);
        win_above[1] = 1'b0;
        negs(3);
        wait_ticks(FILT);
        negs(2);
        chk_eq("R7 rail2 power good", rst_out_n, 3'b111);
        win_below[2] = 1'b1;
        negs(3);
        wait_ticks(FILT);
        negs(2);
        chk_eq("R6 external excursion only", rst_out_n, 3'b011);
        win_below[2] = 1'b0;
        negs(3);
        wait_ticks(FILT + DX - 2);
        chk_eq("R7 external delay not yet", rst_out_n[2], 0);
        wait_ticks(3);
        negs(2);
        chk_eq("R7 external released", rst_out_n[2], 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_power_up();
        t_routing();
        t_fault();
        t_short();
        t_enable();
        t_window();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule